// File: doc/BRIEF.md
# Cascaded Interrupt Pair with Acknowledge Vector

This block joins two eight-line interrupt resolver cores, one acting as master and one as slave, and turns an acknowledge from the processor into an 8-bit interrupt vector. Each core keeps a pending set, an edge-history set and an in-service set per line. Lines can be edge- or level-sensitive, and any line can be masked. A fixed priority picks the winning line in each core: line 0 is highest. A line is deliverable only if it beats every line already in service in that core.

Sixteen interrupt sources report their level changes through a single indexed strobe. The slave's deliverable state feeds the master on master line 2 as a momentary edge. The processor-facing request is a registered copy of the master's deliverable state. A one-cycle acknowledge strobe does three things: it resolves the master winner, acknowledges the slave when that winner is the cascade line, and registers the vector one cycle later. When no line is available, it produces spurious vectors instead. An end-of-interrupt strobe retires the top in-service line of either core.

Top module: `pic_cascade_ack`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cpu_irq`, `vec_valid` and `vec` are all zero.
- R2: A request strobe with `req_idx` bit 3 low targets master line `req_idx[2:0]`. With bit 3 high it targets slave line `req_idx[2:0]`.
- R3: For an edge line (`line_lvl_mode` bit 0), a request is latched only on a 0-to-1 change of the reported level. For a level line (bit 1), the pending bit follows the reported level, both setting and clearing.
- R4: Within a core, a line is deliverable when it is pending and unmasked (`line_mask` bit = 1 masks it). It must also have a lower number than every in-service line of that core. The lowest-numbered deliverable line wins.
- R5: In every cycle with no request, acknowledge or end-of-interrupt strobe, a deliverable slave sets master line 2 pending and clears its edge history. Master line 2 is always treated as edge-sensitive, whatever `line_lvl_mode[2]` says.
- R6: `cpu_irq` is high in the cycle after one in which the master has a deliverable line, and low otherwise.
- R7: `vec_valid` is high for exactly the one cycle after `inta`. `vec` then holds the upper five bits of the responding core's base, followed by a 3-bit line number; the low three base bits are ignored.
- R8: On acknowledge, the master winner is marked in service. Its pending bit is cleared if the line is edge-sensitive and kept if it is level-sensitive.
- R9: An acknowledge with no deliverable master line returns master base with line 7 and changes no in-service bit.
- R10: If the master winner is line 2, the slave winner is acknowledged by the rule of R8 and the vector uses the slave base and line. If the slave has no deliverable line, the vector is slave base with line 7.
- R11: An end-of-interrupt strobe clears the lowest-numbered in-service bit of the core chosen by `eoi_slave` (0 master, 1 slave).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | 1 | Source level-change strobe |
| req_idx | input | 4 | Global source index 0 to 15 |
| req_lvl | input | 1 | New level of the indexed source |
| line_mask | input | 16 | Per-source mask, 1 blocks delivery |
| line_lvl_mode | input | 16 | Per-source trigger mode, 1 level, 0 edge |
| mst_base | input | 8 | Master vector base |
| slv_base | input | 8 | Slave vector base |
| inta | input | 1 | One-cycle acknowledge strobe |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| eoi_slave | input | 1 | End-of-interrupt target, 1 slave |
| cpu_irq | output | 1 | Registered request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |
| vec | output | 8 | Interrupt vector |

## Verification
The hardest state to reach is a slave-spurious acknowledge. In that state, master line 2 is latched from the cascade but the slave has nothing left to deliver. The directed stimulus gets there with a level-sensitive slave line: it raises the line so the cascade latches master line 2, then drops the line so the slave's pending bit clears while the master's edge remains. It then acknowledges and expects the slave base with line 7. Random sequences of level changes, masks, acknowledges and end-of-interrupts are compared against a reference model in the bench. That comparison reaches nested in-service blocking and further cascade cases.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int LINE_W    = 3;
  localparam int NLINES    = 1 << LINE_W;
  localparam int VEC_W     = 8;
  localparam int CASC_LINE = 2;

  typedef enum logic {
    SEL_MST = 1'b0,
    SEL_SLV = 1'b1
  } core_sel_e;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pic_line_core.sv
module pic_line_core #(
  parameter int N         = 8,
  parameter int W         = 3,
  parameter int CASC_LINE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic [W-1:0] set_line,
  input  logic         set_lvl,
  input  logic         casc_pulse,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] lvl_mode,
  input  logic         ack_stb,
  input  logic         eoi_stb,
  output logic         has_win,
  output logic [W-1:0] win_line
);
  logic [N-1:0] irr_q, last_q, isr_q;
  logic [N-1:0] irr_d, last_d, isr_d;
  logic         pend_any, svc_any;
  logic [W-1:0] pend_idx, svc_idx;

  pic_prio_enc #(.N(N), .W(W)) u_pend_enc (
    .req (irr_q & ~mask),
    .any (pend_any),
    .idx (pend_idx)
  );

  pic_prio_enc #(.N(N), .W(W)) u_svc_enc (
    .req (isr_q),
    .any (svc_any),
    .idx (svc_idx)
  );

  assign has_win  = pend_any && (!svc_any || (pend_idx < svc_idx));
  assign win_line = pend_idx;

  always_comb begin
    irr_d  = irr_q;
    last_d = last_q;
    isr_d  = isr_q;
    if (set_stb) begin
      if (lvl_mode[set_line]) begin
        irr_d[set_line] = set_lvl;
      end else if (set_lvl && !last_q[set_line]) begin
        irr_d[set_line] = 1'b1;
      end
      last_d[set_line] = set_lvl;
    end
    if (ack_stb && has_win) begin
      isr_d[pend_idx] = 1'b1;
      if (!lvl_mode[pend_idx]) irr_d[pend_idx] = 1'b0;
    end
    if (eoi_stb && svc_any) isr_d[svc_idx] = 1'b0;
    if (casc_pulse) begin
      irr_d[CASC_LINE]  = 1'b1;
      last_d[CASC_LINE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= last_d;
      isr_q  <= isr_d;
    end
  end

  // R8: an acknowledged winner is in service next cycle
  a_r8_isr_set: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && has_win && !eoi_stb) |=> isr_q[$past(win_line)]);

  // R9: acknowledge without a winner leaves in-service untouched
  a_r9_no_spur_isr: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !has_win && !eoi_stb) |=> $stable(isr_q));

  // R5: a cascade pulse leaves the cascade line pending
  a_r5_casc_latch: assert property (@(posedge clk) disable iff (rst)
    casc_pulse |=> irr_q[CASC_LINE]);

  // R3: a level line reported low is no longer pending
  a_r3_level_clear: assert property (@(posedge clk) disable iff (rst)
    (set_stb && !set_lvl && lvl_mode[set_line] && !casc_pulse)
      |=> !irr_q[$past(set_line)]);

  // R11: end-of-interrupt retires exactly one in-service bit
  a_r11_eoi_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_stb && !ack_stb && (isr_q != '0))
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
  import pic_cascade_pkg::*;
#(
  parameter int LW = LINE_W,
  parameter int VW = VEC_W,
  parameter int CL = CASC_LINE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_stb,
  input  logic [LW:0]       req_idx,
  input  logic              req_lvl,
  input  logic [2*(1<<LW)-1:0] line_mask,
  input  logic [2*(1<<LW)-1:0] line_lvl_mode,
  input  logic [VW-1:0]     mst_base,
  input  logic [VW-1:0]     slv_base,
  input  logic              inta,
  input  logic              eoi_stb,
  input  logic              eoi_slave,
  output logic              cpu_irq,
  output logic              vec_valid,
  output logic [VW-1:0]     vec
);
  localparam int NL = 1 << LW;
  localparam logic [NL-1:0] CASC_BIT = {{(NL-1){1'b0}}, 1'b1} << CL;
  localparam logic [LW-1:0] SPUR_LINE = {LW{1'b1}};

  logic [1:0]         has_win;
  logic [1:0][LW-1:0] win_line;
  logic               casc;
  logic               slv_ack;
  logic [VW-1:0]      vec_d;

  // cascade only in quiet cycles so it always sees settled slave state
  assign casc    = has_win[SEL_SLV] && !inta && !req_stb && !eoi_stb;
  assign slv_ack = inta && has_win[SEL_MST] && (win_line[SEL_MST] == LW'(CL));

  for (genvar g = 0; g < 2; g++) begin : g_core
    logic [NL-1:0] lm;
    logic          cp, ak, st, eo;
    if (g == 0) begin : g_mst
      assign lm = line_lvl_mode[NL-1:0] & ~CASC_BIT;
      assign cp = casc;
      assign ak = inta;
    end else begin : g_slv
      assign lm = line_lvl_mode[2*NL-1:NL];
      assign cp = 1'b0;
      assign ak = slv_ack;
    end
    assign st = req_stb && (req_idx[LW] == 1'(g));
    assign eo = eoi_stb && (eoi_slave == 1'(g));

    pic_line_core #(.N(NL), .W(LW), .CASC_LINE(CL)) u_core (
      .clk        (clk),
      .rst        (rst),
      .set_stb    (st),
      .set_line   (req_idx[LW-1:0]),
      .set_lvl    (req_lvl),
      .casc_pulse (cp),
      .mask       (line_mask[g*NL +: NL]),
      .lvl_mode   (lm),
      .ack_stb    (ak),
      .eoi_stb    (eo),
      .has_win    (has_win[g]),
      .win_line   (win_line[g])
    );
  end

  always_comb begin
    if (!has_win[SEL_MST]) begin
      vec_d = {mst_base[VW-1:LW], SPUR_LINE};
    end else if (win_line[SEL_MST] == LW'(CL)) begin
      vec_d = has_win[SEL_SLV] ? {slv_base[VW-1:LW], win_line[SEL_SLV]}
                               : {slv_base[VW-1:LW], SPUR_LINE};
    end else begin
      vec_d = {mst_base[VW-1:LW], win_line[SEL_MST]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      cpu_irq   <= has_win[SEL_MST];
      vec_valid <= inta;
      if (inta) vec <= vec_d;
    end
  end

  // R7: valid follows the acknowledge strobe by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inta |=> vec_valid);
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    !inta |=> !vec_valid);

  // R9: no master winner yields the master spurious vector
  a_r9_spur_vec: assert property (@(posedge clk) disable iff (rst)
    (inta && !has_win[SEL_MST])
      |=> (vec == {$past(mst_base[VW-1:LW]), SPUR_LINE}));

  // R6: the processor request tracks the master winner
  a_r6_irq_track: assert property (@(posedge clk) disable iff (rst)
    (has_win[SEL_MST] && !inta && !eoi_stb && !req_stb) |=> cpu_irq);
endmodule

// File: tb/pic_cascade_ack_bench.sv
`timescale 1ns/1ps
module pic_cascade_ack_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_stb = 1'b0;
  logic [3:0]  req_idx = '0;
  logic        req_lvl = 1'b0;
  logic [15:0] line_mask = '0;
  logic [15:0] line_lvl_mode = '0;
  logic [7:0]  mst_base = '0;
  logic [7:0]  slv_base = '0;
  logic        inta = 1'b0;
  logic        eoi_stb = 1'b0;
  logic        eoi_slave = 1'b0;
  logic        cpu_irq, vec_valid;
  logic [7:0]  vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_irr [2];
  logic [7:0] m_last[2];
  logic [7:0] m_isr [2];

  always #2 clk = ~clk;

  pic_cascade_ack u_pic_cascade_ack (
    .clk(clk), .rst(rst), .req_stb(req_stb), .req_idx(req_idx),
    .req_lvl(req_lvl), .line_mask(line_mask), .line_lvl_mode(line_lvl_mode),
    .mst_base(mst_base), .slv_base(slv_base), .inta(inta),
    .eoi_stb(eoi_stb), .eoi_slave(eoi_slave), .cpu_irq(cpu_irq),
    .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int prio(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] mmask(input int g);
    return (g == 0) ? line_mask[7:0] : line_mask[15:8];
  endfunction

  function automatic logic [7:0] mlvl(input int g);
    return (g == 0) ? (line_lvl_mode[7:0] & 8'hFB) : line_lvl_mode[15:8];
  endfunction

  function automatic int winner(input int g);
    int p, s;
    p = prio(m_irr[g] & ~mmask(g));
    s = prio(m_isr[g]);
    return (p < 8 && p < s) ? p : -1;
  endfunction

  task automatic settle();
    if (winner(1) >= 0) begin
      m_irr[0][2]  = 1'b1;
      m_last[0][2] = 1'b0;
    end
  endtask

  task automatic idle_check(input string tag);
    repeat (4) @(negedge clk);
    chk(tag, {7'd0, cpu_irq}, {7'd0, winner(0) >= 0});
  endtask

  task automatic do_set(input logic [3:0] idx, input logic lvl, input string tag);
    int g, l;
    @(negedge clk);
    req_stb = 1'b1; req_idx = idx; req_lvl = lvl;
    @(negedge clk);
    req_stb = 1'b0;
    g = idx[3]; l = idx[2:0];
    if (mlvl(g)[l]) begin
      m_irr[g][l]  = lvl;
    end else if (lvl && !m_last[g][l]) begin
      m_irr[g][l] = 1'b1;
    end
    m_last[g][l] = lvl;
    settle();
    idle_check(tag);
  endtask

  task automatic do_ack(input string tag);
    int w, ws;
    logic [7:0] exp;
    w = winner(0);
    if (w < 0) begin
      exp = {mst_base[7:3], 3'd7};
    end else begin
      m_isr[0][w] = 1'b1;
      if (!mlvl(0)[w]) m_irr[0][w] = 1'b0;
      if (w == 2) begin
        ws = winner(1);
        if (ws < 0) exp = {slv_base[7:3], 3'd7};
        else begin
          exp = {slv_base[7:3], 3'(ws)};
          m_isr[1][ws] = 1'b1;
          if (!mlvl(1)[ws]) m_irr[1][ws] = 1'b0;
        end
      end else exp = {mst_base[7:3], 3'(w)};
    end
    settle();
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk({tag, " valid R7"}, {7'd0, vec_valid}, 8'd1);
    chk({tag, " vector"}, vec, exp);
    @(negedge clk);
    chk("R7 valid drops", {7'd0, vec_valid}, 8'd0);
    idle_check({tag, " irq R6"});
  endtask

  task automatic do_eoi(input logic sl, input string tag);
    int s;
    @(negedge clk);
    eoi_stb = 1'b1; eoi_slave = sl;
    @(negedge clk);
    eoi_stb = 1'b0;
    s = prio(m_isr[sl]);
    if (s < 8) m_isr[sl][s] = 1'b0;
    settle();
    idle_check(tag);
  endtask

  task automatic do_mask(input logic [15:0] m);
    @(negedge clk);
    line_mask = m;
    settle();
    idle_check("R4 mask change");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int g = 0; g < 2; g++) begin
      m_irr[g] = '0; m_last[g] = '0; m_isr[g] = '0;
    end
    mst_base = 8'h23; slv_base = 8'h7D;
    line_lvl_mode = 16'h0804;
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {7'd0, cpu_irq}, 8'd0);
    chk("R1 reset valid", {7'd0, vec_valid}, 8'd0);
    chk("R1 reset vec", vec, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset irq", {7'd0, cpu_irq}, 8'd0);

    do_ack("R9 empty master");
    do_set(4'd5, 1'b1, "R2 master line 5");
    do_set(4'd1, 1'b1, "R3 edge latch");
    do_ack("R4 line 1 over 5");
    do_ack("R4 blocked by in-service");
    do_eoi(1'b0, "R11 master eoi");
    do_ack("R8 line 5");
    do_eoi(1'b0, "R11 master eoi 2");
    do_set(4'd4, 1'b1, "R3 held high no relatch");
    do_ack("R8 line 4");
    do_eoi(1'b0, "R11 eoi");
    do_ack("R3 no relatch spurious");
    do_set(4'd11, 1'b1, "R5 slave level cascade");
    do_ack("R10 slave vector");
    do_eoi(1'b1, "R11 slave eoi");
    do_eoi(1'b0, "R11 master eoi 3");
    do_set(4'd11, 1'b0, "R3 slave level drop");
    do_ack("R10 slave spurious");
    do_eoi(1'b0, "R11 master eoi 4");
    do_set(4'd2, 1'b1, "R5 line 2 edge");
    do_ack("R5 line 2 treated edge");
    do_eoi(1'b0, "R11 clean");
    do_eoi(1'b1, "R11 clean slave");

    line_lvl_mode = 16'($urandom) & 16'hA5C3;
    mst_base = 8'($urandom);
    slv_base = 8'($urandom);
    @(negedge clk);
    settle();
    for (int it = 0; it < 700; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 4) do_set(4'($urandom), 1'($urandom), "R3 random set");
      else if (op <= 6) do_ack("R10 random ack");
      else if (op <= 8) do_eoi(1'($urandom), "R11 random eoi");
      else do_mask(16'($urandom) & 16'($urandom) & 16'($urandom));
    end
    finish_run();
  end
endmodule